// File: doc/BRIEF.md
# Flash Register Command Sequencer

This block is a bus master that carries out page read, page program and block erase on a memory-mapped flash controller. It does this through a fixed series of register writes and reads. A client raises a request with an operation code, a logical 512-byte page number and a byte column. The sequencer then walks a step list over a one-access-at-a-time valid/ready register port. The list covers a common reset preamble, an operation-specific body and, for program and erase, a shared closing tail that collects three status words. Each delay in the series is an explicit write of zero to a no-op register, never a run of idle cycles. Each wait for the flash is a ready-bit poll that begins with one read whose value is thrown away.

The logical page is packed into a 32-bit device address. The upper half holds the 2K page number (page/4). The lower half holds a half-word index that counts out-of-band bytes, so each 512-byte sub-page is 0x108 half-words apart. The address goes out as byte writes, least significant first. When the sequence ends, the block pulses `done` with a pass/fail flag. A failure is also latched until a status query collects it once. A poll that never sees ready is cut off by a timeout counter, so a stuck controller cannot hang the block.

Register offsets, command and sequence codes, the good status values and the ready mask are parameters. The data phase of page contents, ECC decoding and the flash array are outside this block.

Top module: `flash_seq`

## Requirements
- R1: After reset, req_ready is 1 and bus_valid, done and stat_ack are 0.
- R2: While bus_valid is 1 and bus_ready is 0, bus_valid, bus_write, bus_addr and bus_wdata hold their values. req_ready is 0 from the cycle after a request is accepted until the operation ends.
- R3: Every operation (req_op 0 read, 1 program, 2 erase, 3 preamble only) starts with this order of accesses: control register written with the chip-enable code, sequence register written with the reset code, command register written with the reset command, two no-ops, a ready poll, one no-op. A no-op is a write of 0 to the no-op register.
- R4: A ready poll reads the control register once and ignores the value, even when that value shows ready. It then rereads the control register until (rdata & ready mask) is nonzero.
- R5: The device address is ((page/4)<<16) | ((page%4)*0x108 + column/2). Each address byte is written to the address register as a 16-bit word with the byte in bits 7:0 and zeros above. For read and program, all four bytes are sent, bits 7:0 first and bits 31:24 last.
- R6: After the preamble, a read writes the read sequence code, the read command, one no-op, the four address bytes, one no-op and the second read command. It then issues two no-ops and a ready poll, and ends with no status words.
- R7: After the preamble, a program writes the write sequence code, the write command, one no-op and the four address bytes. It then issues two no-ops, a ready poll, the program sequence code, the program-confirm command, two no-ops and a ready poll, followed by the closing tail.
- R8: After the preamble, an erase writes the erase sequence code, the block-address command and one no-op. It then sends only address bits 23:16 and 31:24, in that order, followed by one no-op, the erase-confirm command, two no-ops, a ready poll and the closing tail.
- R9: The closing tail writes the flush sequence code and the flush command. It writes the ECC configuration register with the read-mode code ORed with 4, and issues five no-ops. It reads the data register twice and the auxiliary register once, writes 0 to the data-end register, and finishes with a no-op, a ready poll and a final no-op.
- R10: A program or erase fails when the first status word differs from the first good value, or when the second or third differs from the second good value. A read never fails except by timeout.
- R11: A failure is latched. A one-cycle stat_req gives a one-cycle stat_ack on the next cycle, with stat_fail equal to the latched flag, and the flag is then cleared. Several failures before a query are reported once.
- R12: If POLL_LIMIT consecutive poll reads after the discarded read all show not-ready, the operation ends with done_fail=1 and done_tmo=1, and no further bus access is made.
- R13: done is a one-cycle pulse. done_fail and done_tmo are valid with it, and req_ready is 1 in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Sequencer idle; request accepted when both are high |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 preamble only |
| req_page | input | PAGE_W | Logical 512-byte page number |
| req_col | input | COL_W | Byte column within the page |
| done | output | 1 | One-cycle end-of-operation pulse |
| done_fail | output | 1 | Operation failed (with done) |
| done_tmo | output | 1 | Failure was a poll timeout (with done) |
| stat_req | input | 1 | Status query |
| stat_ack | output | 1 | Query answer strobe |
| stat_fail | output | 1 | Latched failure flag returned with stat_ack |
| bus_valid | output | 1 | Register access request |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | REG_AW | Register offset |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Access completes this cycle |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready |

## Verification
Each register access takes one step-fetch cycle plus at least one cycle waiting for bus_ready. The scripted responder therefore compares every access at the falling edge where it raises bus_ready, and it is run with response latencies of zero, one and two cycles. done is registered and appears one cycle after the final access completes, so the bench scans falling edges until it sees the pulse. At that edge it checks done_fail, done_tmo and that the expected access queue is empty, and one edge later it checks that req_ready has returned. A status query raised at a falling edge is answered at the next falling edge, and the bench always waits one cycle after done before querying so that the latch has taken the failure.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  parameter int unsigned REG_AW = 8;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned PC_W = 6;
  parameter int unsigned ECC_COUNT = 4;
  parameter int unsigned SUB_BYTES = 512;
  parameter int unsigned SPARE_BYTES = 16;
  localparam int unsigned SUB_STRIDE = (SUB_BYTES + SPARE_BYTES) / 2;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_PRE = 2'd3} op_e;
  typedef enum logic [2:0] {K_WR, K_DISC, K_POLL, K_STAT, K_END} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT} seq_st_e;

  typedef struct packed {
    kind_e kind;
    logic [REG_AW-1:0] reg_off;
    logic [DATA_W-1:0] data;
  } step_t;

  typedef struct packed {
    logic [REG_AW-1:0] r_ctrl, r_seq, r_cmd, r_addr, r_nop, r_ecc, r_data, r_aux, r_dend;
    logic [DATA_W-1:0] c_ce, s_rst, c_rst, s_rd, c_rd, c_rd2, s_wr, c_wr, s_pg, c_pg2;
    logic [DATA_W-1:0] s_er, c_ba, c_er2, s_fl, c_fl, ecc_rd, good1, good2, rdy;
  } cfg_t;

  localparam cfg_t CFG_DEF = '{
    r_ctrl: 8'h10, r_seq: 8'h12, r_cmd: 8'h14, r_addr: 8'h16, r_nop: 8'h18,
    r_ecc: 8'h1A, r_data: 8'h00, r_aux: 8'h1C, r_dend: 8'h1E,
    c_ce: 16'h0011, s_rst: 16'h00A0, c_rst: 16'h00FF, s_rd: 16'h00A1, c_rd: 16'h0030,
    c_rd2: 16'h0031, s_wr: 16'h00A2, c_wr: 16'h0080, s_pg: 16'h00A3, c_pg2: 16'h0010,
    s_er: 16'h00A4, c_ba: 16'h0060, c_er2: 16'h00D0, s_fl: 16'h00A5, c_fl: 16'h0070,
    ecc_rd: 16'h8000, good1: 16'h00E0, good2: 16'h0080, rdy: 16'h0004
  };

  function automatic step_t mk(kind_e k, logic [REG_AW-1:0] r, logic [DATA_W-1:0] d);
    step_t s;
    s.kind = k;
    s.reg_off = r;
    s.data = d;
    return s;
  endfunction

endpackage

// File: rtl/flash_seq_addr.sv
module flash_seq_addr
  import flash_seq_pkg::*;
#(
  parameter int unsigned PAGE_W = 18,
  parameter int unsigned COL_W = 10
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [COL_W-1:0]  col,
  output logic [31:0]       dev_addr
);
  logic [15:0] blk;
  logic [15:0] idx;

  assign blk = 16'(page >> 2);
  assign idx = 16'(page[1:0]) * 16'(SUB_STRIDE) + 16'(col >> 1);
  assign dev_addr = {blk, idx};
endmodule

// File: rtl/flash_seq_steps.sv
module flash_seq_steps
  import flash_seq_pkg::*;
#(
  parameter cfg_t CFG = CFG_DEF
) (
  input  op_e             op,
  input  logic [PC_W-1:0] pc,
  input  logic [31:0]     dev_addr,
  output step_t           step
);
  localparam logic [PC_W-1:0] PRE_LEN = PC_W'(8);
  localparam logic [PC_W-1:0] PROG_TAIL = PC_W'(25);
  localparam logic [PC_W-1:0] ERASE_TAIL = PC_W'(19);

  logic [DATA_W-1:0] ab [4];
  logic [PC_W-1:0] tail_at;
  logic [PC_W-1:0] rel;
  step_t nop;

  for (genvar i = 0; i < 4; i++) begin : g_byte
    assign ab[i] = DATA_W'(dev_addr[8*i +: 8]);
  end

  assign nop = mk(K_WR, CFG.r_nop, '0);
  assign tail_at = (op == OP_PROG) ? PROG_TAIL : ERASE_TAIL;
  assign rel = pc - tail_at;

  always_comb begin
    step = mk(K_END, '0, '0);
    if (pc < PRE_LEN) begin
      case (pc)
        6'd0: step = mk(K_WR, CFG.r_ctrl, CFG.c_ce);
        6'd1: step = mk(K_WR, CFG.r_seq, CFG.s_rst);
        6'd2: step = mk(K_WR, CFG.r_cmd, CFG.c_rst);
        6'd5: step = mk(K_DISC, CFG.r_ctrl, '0);
        6'd6: step = mk(K_POLL, CFG.r_ctrl, '0);
        default: step = nop;
      endcase
    end else if ((op == OP_PROG || op == OP_ERASE) && pc >= tail_at) begin
      case (rel)
        6'd0:  step = mk(K_WR, CFG.r_seq, CFG.s_fl);
        6'd1:  step = mk(K_WR, CFG.r_cmd, CFG.c_fl);
        6'd2:  step = mk(K_WR, CFG.r_ecc, CFG.ecc_rd | DATA_W'(ECC_COUNT));
        6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd12, 6'd15: step = nop;
        6'd8:  step = mk(K_STAT, CFG.r_data, CFG.good1);
        6'd9:  step = mk(K_STAT, CFG.r_data, CFG.good2);
        6'd10: step = mk(K_STAT, CFG.r_aux, CFG.good2);
        6'd11: step = mk(K_WR, CFG.r_dend, '0);
        6'd13: step = mk(K_DISC, CFG.r_ctrl, '0);
        6'd14: step = mk(K_POLL, CFG.r_ctrl, '0);
        default: step = mk(K_END, '0, '0);
      endcase
    end else begin
      case (op)
        OP_READ: begin
          case (pc)
            6'd8:  step = mk(K_WR, CFG.r_seq, CFG.s_rd);
            6'd9:  step = mk(K_WR, CFG.r_cmd, CFG.c_rd);
            6'd10, 6'd15, 6'd17, 6'd18: step = nop;
            6'd11: step = mk(K_WR, CFG.r_addr, ab[0]);
            6'd12: step = mk(K_WR, CFG.r_addr, ab[1]);
            6'd13: step = mk(K_WR, CFG.r_addr, ab[2]);
            6'd14: step = mk(K_WR, CFG.r_addr, ab[3]);
            6'd16: step = mk(K_WR, CFG.r_cmd, CFG.c_rd2);
            6'd19: step = mk(K_DISC, CFG.r_ctrl, '0);
            6'd20: step = mk(K_POLL, CFG.r_ctrl, '0);
            default: step = mk(K_END, '0, '0);
          endcase
        end
        OP_PROG: begin
          case (pc)
            6'd8:  step = mk(K_WR, CFG.r_seq, CFG.s_wr);
            6'd9:  step = mk(K_WR, CFG.r_cmd, CFG.c_wr);
            6'd10, 6'd15, 6'd16, 6'd21, 6'd22: step = nop;
            6'd11: step = mk(K_WR, CFG.r_addr, ab[0]);
            6'd12: step = mk(K_WR, CFG.r_addr, ab[1]);
            6'd13: step = mk(K_WR, CFG.r_addr, ab[2]);
            6'd14: step = mk(K_WR, CFG.r_addr, ab[3]);
            6'd17, 6'd23: step = mk(K_DISC, CFG.r_ctrl, '0);
            6'd18, 6'd24: step = mk(K_POLL, CFG.r_ctrl, '0);
            6'd19: step = mk(K_WR, CFG.r_seq, CFG.s_pg);
            6'd20: step = mk(K_WR, CFG.r_cmd, CFG.c_pg2);
            default: step = mk(K_END, '0, '0);
          endcase
        end
        OP_ERASE: begin
          case (pc)
            6'd8:  step = mk(K_WR, CFG.r_seq, CFG.s_er);
            6'd9:  step = mk(K_WR, CFG.r_cmd, CFG.c_ba);
            6'd10, 6'd13, 6'd15, 6'd16: step = nop;
            6'd11: step = mk(K_WR, CFG.r_addr, ab[2]);
            6'd12: step = mk(K_WR, CFG.r_addr, ab[3]);
            6'd14: step = mk(K_WR, CFG.r_cmd, CFG.c_er2);
            6'd17: step = mk(K_DISC, CFG.r_ctrl, '0);
            6'd18: step = mk(K_POLL, CFG.r_ctrl, '0);
            default: step = mk(K_END, '0, '0);
          endcase
        end
        default: step = mk(K_END, '0, '0);
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_errlatch.sv
module flash_seq_errlatch (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic query,
  output logic ack,
  output logic fail_out
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ack <= 1'b0;
      fail_out <= 1'b0;
    end else begin
      ack <= query;
      if (query) fail_out <= pend;
      if (set) pend <= 1'b1;
      else if (query) pend <= 1'b0;
    end
  end

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    query && !set |=> !pend);
  assert_ack_R11: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(query));
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    set |=> pend);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned PAGE_W = 18,
  parameter int unsigned COL_W = 10,
  parameter int unsigned POLL_LIMIT = 1000,
  parameter cfg_t CFG = CFG_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [COL_W-1:0]  req_col,
  output logic              done,
  output logic              done_fail,
  output logic              done_tmo,
  input  logic              stat_req,
  output logic              stat_ack,
  output logic              stat_fail,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [REG_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);

  seq_st_e state;
  op_e op_q;
  logic [31:0] addr_q, addr_in;
  logic [PC_W-1:0] pc;
  logic [CNT_W-1:0] poll_cnt;
  kind_e kind_q;
  logic [DATA_W-1:0] chk_q;
  logic op_fail;
  step_t cur;

  flash_seq_addr #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_addr (
    .page(req_page), .col(req_col), .dev_addr(addr_in));

  flash_seq_steps #(.CFG(CFG)) u_steps (
    .op(op_q), .pc(pc), .dev_addr(addr_q), .step(cur));

  flash_seq_errlatch u_err (
    .clk(clk), .rst(rst), .set(done && done_fail), .query(stat_req),
    .ack(stat_ack), .fail_out(stat_fail));

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      op_q <= OP_READ;
      addr_q <= '0;
      pc <= '0;
      poll_cnt <= '0;
      kind_q <= K_END;
      chk_q <= '0;
      op_fail <= 1'b0;
      done <= 1'b0;
      done_fail <= 1'b0;
      done_tmo <= 1'b0;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr <= '0;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q <= op_e'(req_op);
            addr_q <= addr_in;
            pc <= '0;
            op_fail <= 1'b0;
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (cur.kind == K_END) begin
            done <= 1'b1;
            done_fail <= op_fail;
            done_tmo <= 1'b0;
            state <= S_IDLE;
          end else begin
            bus_valid <= 1'b1;
            bus_write <= (cur.kind == K_WR);
            bus_addr <= cur.reg_off;
            bus_wdata <= (cur.kind == K_WR) ? cur.data : '0;
            kind_q <= cur.kind;
            chk_q <= cur.data;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            state <= S_LOAD;
            case (kind_q)
              K_DISC: begin
                pc <= pc + 1'b1;
                poll_cnt <= '0;
              end
              K_POLL: begin
                if ((bus_rdata & CFG.rdy) != '0) begin
                  pc <= pc + 1'b1;
                end else if (poll_cnt == CNT_W'(POLL_LIMIT - 1)) begin
                  done <= 1'b1;
                  done_fail <= 1'b1;
                  done_tmo <= 1'b1;
                  state <= S_IDLE;
                end else begin
                  poll_cnt <= poll_cnt + 1'b1;
                end
              end
              K_STAT: begin
                if (bus_rdata != chk_q) op_fail <= 1'b1;
                pc <= pc + 1'b1;
              end
              default: pc <= pc + 1'b1;
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      assert_poll_bound_R12: assert (poll_cnt < CNT_W'(POLL_LIMIT))
        else $error("poll counter past its limit");
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write));
  assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !req_ready);
  assert_nop_zero_R3: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && bus_addr == CFG.r_nop |-> bus_wdata == '0);
  assert_tmo_fail_R12: assert property (@(posedge clk) disable iff (rst)
    done && done_tmo |-> done_fail);
  assert_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && req_ready);
  assert_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_valid);
endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  import flash_seq_pkg::*;

  localparam int LIM = 6;
  localparam cfg_t C = CFG_DEF;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [15:0] d;
    logic [15:0] resp;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [17:0] req_page = '0;
  logic [9:0] req_col = '0;
  logic done, done_fail, done_tmo;
  logic stat_req = 1'b0;
  logic stat_ack, stat_fail;
  logic bus_valid, bus_write;
  logic [7:0] bus_addr;
  logic [15:0] bus_wdata;
  logic bus_ready = 1'b0;
  logic [15:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wcnt = 0;
  item_t exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  flash_seq #(.POLL_LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_page(req_page), .req_col(req_col),
    .done(done), .done_fail(done_fail), .done_tmo(done_tmo),
    .stat_req(stat_req), .stat_ack(stat_ack), .stat_fail(stat_fail),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata));

  task automatic chk(bit ok, string tg, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tg, act, expv);
    end
  endtask

  task automatic pw(logic [7:0] a, logic [15:0] d, string tg);
    exp_q.push_back('{wr: 1'b1, a: a, d: d, resp: 16'h0});
    tag_q.push_back(tg);
  endtask

  task automatic pr(logic [7:0] a, logic [15:0] resp, string tg);
    exp_q.push_back('{wr: 1'b0, a: a, d: 16'h0, resp: resp});
    tag_q.push_back(tg);
  endtask

  task automatic nop(string tg);
    pw(C.r_nop, 16'h0, tg);
  endtask

  // discarded read answers "ready" on purpose; a further read must follow
  task automatic t_poll(int np, string tg);
    pr(C.r_ctrl, C.rdy, {tg, "/R4"});
    for (int i = 0; i < np; i++) pr(C.r_ctrl, ~C.rdy, {tg, "/R4"});
    pr(C.r_ctrl, C.rdy | 16'h0100, {tg, "/R4"});
  endtask

  task automatic t_pre(int np);
    pw(C.r_ctrl, C.c_ce, "R3");
    pw(C.r_seq, C.s_rst, "R3");
    pw(C.r_cmd, C.c_rst, "R3");
    nop("R3"); nop("R3");
    t_poll(np, "R3");
    nop("R3");
  endtask

  function automatic logic [31:0] pack(int page, int col);
    return 32'(((page / 4) << 16) | ((page % 4) * 264 + col / 2));
  endfunction

  task automatic t_addr4(logic [31:0] a, string tg);
    for (int i = 0; i < 4; i++) pw(C.r_addr, {8'h00, a[8*i +: 8]}, {tg, "/R5"});
  endtask

  task automatic t_tail(int np, logic [15:0] s1, logic [15:0] s2, logic [15:0] s3);
    pw(C.r_seq, C.s_fl, "R9");
    pw(C.r_cmd, C.c_fl, "R9");
    pw(C.r_ecc, C.ecc_rd | 16'd4, "R9");
    for (int i = 0; i < 5; i++) nop("R9");
    pr(C.r_data, s1, "R10");
    pr(C.r_data, s2, "R10");
    pr(C.r_aux, s3, "R10");
    pw(C.r_dend, 16'h0, "R9");
    nop("R9");
    t_poll(np, "R9");
    nop("R9");
  endtask

  task automatic q_read(int page, int col, int np);
    t_pre(np);
    pw(C.r_seq, C.s_rd, "R6");
    pw(C.r_cmd, C.c_rd, "R6");
    nop("R6");
    t_addr4(pack(page, col), "R6");
    nop("R6");
    pw(C.r_cmd, C.c_rd2, "R6");
    nop("R6"); nop("R6");
    t_poll(np, "R6");
  endtask

  task automatic q_prog(int page, int col, int np, logic [15:0] s1, logic [15:0] s2, logic [15:0] s3);
    t_pre(np);
    pw(C.r_seq, C.s_wr, "R7");
    pw(C.r_cmd, C.c_wr, "R7");
    nop("R7");
    t_addr4(pack(page, col), "R7");
    nop("R7"); nop("R7");
    t_poll(np, "R7");
    pw(C.r_seq, C.s_pg, "R7");
    pw(C.r_cmd, C.c_pg2, "R7");
    nop("R7"); nop("R7");
    t_poll(np, "R7");
    t_tail(np, s1, s2, s3);
  endtask

  task automatic q_erase(int page, int np, logic [15:0] s1, logic [15:0] s2, logic [15:0] s3);
    logic [31:0] a;
    a = pack(page, 0);
    t_pre(np);
    pw(C.r_seq, C.s_er, "R8");
    pw(C.r_cmd, C.c_ba, "R8");
    nop("R8");
    pw(C.r_addr, {8'h00, a[23:16]}, "R8/R5");
    pw(C.r_addr, {8'h00, a[31:24]}, "R8/R5");
    nop("R8");
    pw(C.r_cmd, C.c_er2, "R8");
    nop("R8"); nop("R8");
    t_poll(np, "R8");
    t_tail(np, s1, s2, s3);
  endtask

  // scoreboard monitor / scripted register responder
  initial begin
    forever begin
      @(negedge clk);
      bus_ready = 1'b0;
      if (!rst && bus_valid) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R12 unexpected access", {23'h0, bus_write, bus_addr}, 32'h0);
            bus_rdata = 16'h0;
          end else begin
            item_t it;
            string tg;
            it = exp_q.pop_front();
            tg = tag_q.pop_front();
            chk(bus_write == it.wr && bus_addr == it.a && (!it.wr || bus_wdata == it.d), tg,
                {7'h0, bus_write, bus_addr, bus_wdata}, {7'h0, it.wr, it.a, it.d});
            bus_rdata = it.resp;
          end
          bus_ready = 1'b1;
        end
      end
    end
  end

  task automatic run_op(int op, int page, int col, bit exp_fail, bit exp_tmo, string tg);
    int n;
    @(negedge clk);
    req_op = 2'(op);
    req_page = 18'(page);
    req_col = 10'(col);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after accept", 32'(req_ready), 32'h0);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, {tg, " R13 done seen"}, 32'(done), 32'h1);
    chk(done_fail == exp_fail, {tg, " R10 done_fail"}, 32'(done_fail), 32'(exp_fail));
    chk(done_tmo == exp_tmo, {tg, " R12 done_tmo"}, 32'(done_tmo), 32'(exp_tmo));
    chk(exp_q.size() == 0, {tg, " all accesses made"}, 32'(exp_q.size()), 32'h0);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, {tg, " R13 pulse ends, idle"},
        {30'h0, done, req_ready}, 32'h1);
  endtask

  task automatic query(bit expv, string tg);
    @(negedge clk);
    stat_req = 1'b1;
    @(negedge clk);
    stat_req = 1'b0;
    chk(stat_ack == 1'b1, {tg, " R11 stat_ack"}, 32'(stat_ack), 32'h1);
    chk(stat_fail == expv, {tg, " R11 stat_fail"}, 32'(stat_fail), 32'(expv));
    @(negedge clk);
    chk(stat_ack == 1'b0, {tg, " R11 ack one cycle"}, 32'(stat_ack), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
    chk(bus_valid == 1'b0, "R1 bus_valid", 32'(bus_valid), 32'h0);
    chk(done == 1'b0 && stat_ack == 1'b0, "R1 done/stat_ack", {30'h0, done, stat_ack}, 32'h0);

    lat = 0;
    q_read(32'h201, 0, 0);
    run_op(0, 32'h201, 0, 1'b0, 1'b0, "read 0x201");
    query(1'b0, "no failure pending");

    lat = 2;
    q_read(3, 32'h1FE, 3);
    run_op(0, 3, 32'h1FE, 1'b0, 1'b0, "read 3/0x1FE slow R2");

    lat = 1;
    q_prog(32'h12345, 32'h40, 1, C.good1, C.good2, C.good2);
    run_op(1, 32'h12345, 32'h40, 1'b0, 1'b0, "program good");
    query(1'b0, "after good program");

    q_erase(32'h3FFFF, 0, 16'h00E1, C.good2, C.good2);
    run_op(2, 32'h3FFFF, 0, 1'b1, 1'b0, "erase bad word1");
    query(1'b1, "erase failure reported");
    query(1'b0, "failure cleared");

    lat = 0;
    q_prog(5, 0, 2, C.good1, C.good2, 16'h0081);
    run_op(1, 5, 0, 1'b1, 1'b0, "program bad word3");
    q_erase(8, 1, C.good1, 16'h0000, C.good2);
    run_op(2, 8, 0, 1'b1, 1'b0, "erase bad word2");
    query(1'b1, "two failures one report");
    query(1'b0, "reported once");

    t_pre(2);
    run_op(3, 0, 0, 1'b0, 1'b0, "R3 preamble only");

    pw(C.r_ctrl, C.c_ce, "R3");
    pw(C.r_seq, C.s_rst, "R3");
    pw(C.r_cmd, C.c_rst, "R3");
    nop("R3"); nop("R3");
    pr(C.r_ctrl, 16'h0, "R12");
    for (int i = 0; i < LIM; i++) pr(C.r_ctrl, ~C.rdy, "R12");
    run_op(0, 7, 0, 1'b1, 1'b1, "R12 timeout");
    repeat (8) @(negedge clk);
    chk(bus_valid == 1'b0, "R12 quiet after timeout", 32'(bus_valid), 32'h0);
    query(1'b1, "R12 timeout latched");

    q_read(32'h10, 32'h20, 0);
    run_op(0, 32'h10, 32'h20, 1'b0, 1'b0, "read after timeout");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule